// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block decides, for a five-stage in-order integer pipeline, where each ALU operand of the instruction in execute should come from. It also decides when the front of the pipeline must wait. The pipeline stages are fetch, decode/register read, execute, memory and write-back. Each instruction reads its operands in decode and writes its result in write-back. Because of that fixed timing, only read-after-write conflicts can arise, so no logic handles the other two orderings.

For each execute-stage source register, the unit compares the register number against the destinations held in the execute/memory and memory/write-back pipeline registers. It returns a 2-bit select for the operand mux. The newer producer wins when both match. A loaded value is not ready until the end of the memory stage, so a load in execute whose destination is read by the instruction in decode cannot be covered by forwarding. In that case the unit freezes the PC and the fetch/decode register for one cycle and turns the decode/execute register into a bubble. The register file writes early in the cycle, so decode already sees a value being written back, and no path from three stages ahead is needed. The unit is purely combinational: every output follows its inputs within the same cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the execute/memory entry has its write enable set, is not a load, has a non-zero destination, and that destination equals an execute source, the select for that operand is 2'b10.
- R2: When only the memory/write-back entry (write enable set, non-zero destination) matches an execute source, the select for that operand is 2'b01.
- R3: When both later entries qualify for the same source, the select is 2'b10 (execute/memory has priority).
- R4: A source register number of 0 always gives select 2'b00, even if a later entry names register 0 with its write enable set.
- R5: An entry whose write enable is clear never causes forwarding. With no qualifying entry, the select is 2'b00 (register file).
- R6: An execute/memory entry flagged as a load is not forwarded. The select falls back to 2'b01 if the write-back entry matches, and to 2'b00 otherwise.
- R7: When the execute-stage instruction is a load with its write enable set and a non-zero destination, and that destination equals a used decode source (either of the two), both `stall` and `bubble` are 1.
- R8: `stall` and `bubble` stay 0 in four cases: the execute instruction is not a load, its write enable is clear, its destination is register 0, or the matching decode source is marked unused.
- R9: The two operand selects are computed independently. Each depends only on its own execute source number, so they may differ in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register number of the instruction in decode |
| id_rs2 | input | REG_W | Second source register number of the instruction in decode |
| id_rs1_used | input | 1 | Decode instruction actually reads its first source |
| id_rs2_used | input | 1 | Decode instruction actually reads its second source |
| ex_rs1 | input | REG_W | First source register number of the instruction in execute |
| ex_rs2 | input | REG_W | Second source register number of the instruction in execute |
| ex_rd | input | REG_W | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination held in the execute/memory register |
| mem_wen | input | 1 | Execute/memory entry writes a register |
| mem_is_load | input | 1 | Execute/memory entry is a load |
| wb_rd | input | REG_W | Destination held in the memory/write-back register |
| wb_wen | input | 1 | Memory/write-back entry writes a register |
| fwd_a_sel | output | 2 | First ALU operand source: 00 register file, 01 write-back, 10 execute/memory |
| fwd_b_sel | output | 2 | Second ALU operand source, same encoding |
| stall | output | 1 | Hold PC and the fetch/decode register this cycle |
| bubble | output | 1 | Load a no-op into the decode/execute register this cycle |

## Verification
No register lies between any input and any output, so the selects, `stall` and `bubble` are all due in the same cycle the pipeline-register contents are applied. The bench changes inputs just after a rising edge. It reads the outputs at the following falling edge, half a period later, when every path has settled and before the next stimulus. Each vector is therefore checked against the exact inputs that produced it, with no delay to count.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Operand mux encoding shared by the unit and the datapath
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/hz_producer_match.sv
// One comparison of a consumer source against a producer destination.
// veto suppresses the match (used for a load that is too early to forward,
// or for a producer that is not a load in the interlock check).
module hz_producer_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wen,
    input  logic             veto,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && !veto && (dst != ZERO_REG) && (dst == src);
    end

endmodule

// File: rtl/hz_operand_sel.sv
// Priority select for one ALU operand: execute/memory first, then write-back.
module hz_operand_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_src,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic [1:0]       sel
);
    logic     hit_mem;
    logic     hit_wb;
    fwd_sel_e sel_d;

    hz_producer_match #(.REG_W(REG_W)) u_mem_cmp (
        .src (ex_src),
        .dst (mem_rd),
        .wen (mem_wen),
        .veto(mem_is_load),
        .hit (hit_mem)
    );

    hz_producer_match #(.REG_W(REG_W)) u_wb_cmp (
        .src (ex_src),
        .dst (wb_rd),
        .wen (wb_wen),
        .veto(1'b0),
        .hit (hit_wb)
    );

    always_comb begin
        sel_d = FWD_RF;
        if (hit_mem) begin
            sel_d = FWD_MEM;
        end else if (hit_wb) begin
            sel_d = FWD_WB;
        end
    end

    assign sel = sel_d;

    always_comb begin
        if (!$isunknown({ex_src, mem_rd, mem_wen, mem_is_load, wb_rd, wb_wen, sel})) begin
            p_zero_src_rf_r4: assert (ex_src != '0 || sel == 2'b00)
                else $error("register 0 forwarded");
            p_no_wen_rf_r5: assert (mem_wen || wb_wen || sel == 2'b00)
                else $error("forward without a writer");
            p_load_not_fwd_r6: assert (!mem_is_load || sel != 2'b10)
                else $error("load forwarded from execute/memory");
            p_mem_wins_r3: assert (!(mem_wen && !mem_is_load && ex_src != '0 && mem_rd == ex_src)
                                   || sel == 2'b10)
                else $error("newer producer not selected");
        end
    end

endmodule

// File: rtl/hz_load_use.sv
// Load-use interlock: the load in execute feeds a used decode source.
module hz_load_use #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
    input  logic [NUM_SRC-1:0]            id_used,
    input  logic [REG_W-1:0]              ex_rd,
    input  logic                          ex_wen,
    input  logic                          ex_is_load,
    output logic                          hold
);
    logic [NUM_SRC-1:0] dep;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_producer_match #(.REG_W(REG_W)) u_cmp (
            .src (id_src[g]),
            .dst (ex_rd),
            .wen (ex_wen & id_used[g]),
            .veto(!ex_is_load),
            .hit (dep[g])
        );
    end

    assign hold = |dep;

    always_comb begin
        if (!$isunknown({ex_rd, ex_wen, ex_is_load, hold})) begin
            p_hold_needs_load_r7: assert (!hold || (ex_is_load && ex_wen))
                else $error("hold without a writing load");
            p_hold_not_zero_r8: assert (!hold || ex_rd != '0)
                else $error("hold on register 0");
        end
    end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs1_used,
    input  logic             id_rs2_used,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             stall,
    output logic             bubble
);
    localparam int NUM_OPS = 2;

    typedef struct packed {
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic       hold;
    } hz_out_t;

    logic [NUM_OPS-1:0][REG_W-1:0] ex_src;
    logic [NUM_OPS-1:0][REG_W-1:0] id_src;
    logic [NUM_OPS-1:0]            id_used;
    logic [NUM_OPS-1:0][1:0]       op_sel;
    logic                          hold;
    hz_out_t                       out_d;

    assign ex_src  = {ex_rs2, ex_rs1};
    assign id_src  = {id_rs2, id_rs1};
    assign id_used = {id_rs2_used, id_rs1_used};

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_operand_sel #(.REG_W(REG_W)) u_sel (
            .ex_src     (ex_src[g]),
            .mem_rd     (mem_rd),
            .mem_wen    (mem_wen),
            .mem_is_load(mem_is_load),
            .wb_rd      (wb_rd),
            .wb_wen     (wb_wen),
            .sel        (op_sel[g])
        );
    end

    hz_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_OPS)) u_interlock (
        .id_src    (id_src),
        .id_used   (id_used),
        .ex_rd     (ex_rd),
        .ex_wen    (ex_wen),
        .ex_is_load(ex_is_load),
        .hold      (hold)
    );

    always_comb begin
        out_d       = '0;
        out_d.sel_a = op_sel[0];
        out_d.sel_b = op_sel[1];
        out_d.hold  = hold;
    end

    assign fwd_a_sel = out_d.sel_a;
    assign fwd_b_sel = out_d.sel_b;
    assign stall     = out_d.hold;
    assign bubble    = out_d.hold;

endmodule

// File: tb/hazard_fwd_unit_tb.sv
`timescale 1ns/1ps
module hazard_fwd_unit_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic       id_rs1_used, id_rs2_used, ex_wen, ex_is_load;
    logic       mem_wen, mem_is_load, wb_wen;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       stall, bubble;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    hazard_fwd_unit #(.REG_W(5)) u_dut (
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall(stall), .bubble(bubble)
    );

    typedef struct packed {
        logic [4:0] ers1; logic [4:0] ers2;
        logic [4:0] mrd;  logic mw; logic ml;
        logic [4:0] wrd;  logic ww;
        logic [4:0] irs1; logic [4:0] irs2; logic iu1; logic iu2;
        logic [4:0] erd;  logic ew; logic el;
        logic [1:0] ea;   logic [1:0] eb; logic es;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R1: execute/memory match on operand a
        '{5'd3, 5'd4, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 4'd1},
        // R2: write-back match only on operand b
        '{5'd5, 5'd6, 5'd7, 1'b1, 1'b0, 5'd6, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, 4'd2},
        // R3: both entries match, newer wins
        '{5'd8, 5'd8, 5'd8, 1'b1, 1'b0, 5'd8, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b10, 2'b10, 1'b0, 4'd3},
        // R4: register 0 everywhere
        '{5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd4},
        // R5: no write enables
        '{5'd9, 5'd9, 5'd9, 1'b0, 1'b0, 5'd9, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5},
        // R5: execute/memory disabled, write-back enabled
        '{5'd9, 5'd2, 5'd9, 1'b0, 1'b0, 5'd9, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd5},
        // R6: load in execute/memory falls back to write-back
        '{5'd10, 5'd10, 5'd10, 1'b1, 1'b1, 5'd10, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b01, 2'b01, 1'b0, 4'd6},
        // R6: load in execute/memory, nothing else: register file
        '{5'd11, 5'd0, 5'd11, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd6},
        // R7: load feeds decode first source
        '{5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd12, 5'd0, 1'b1, 1'b0, 5'd12, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd7},
        // R7: load feeds decode second source
        '{5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd1, 5'd13, 1'b1, 1'b1, 5'd13, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd7},
        // R8: load to register 0
        '{5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 4'd8},
        // R8: producer is not a load
        '{5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd14, 5'd0, 1'b1, 1'b0, 5'd14, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd8},
        // R8: matching source unused
        '{5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd15, 1'b0, 1'b0, 5'd15, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 4'd8},
        // R8: load with write enable clear
        '{5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd16, 5'd0, 1'b1, 1'b0, 5'd16, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 4'd8},
        // R9: operands pick different producers
        '{5'd17, 5'd18, 5'd18, 1'b1, 1'b0, 5'd17, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b01, 2'b10, 1'b0, 4'd9},
        // R7: interlock and forwarding in the same cycle
        '{5'd20, 5'd0, 5'd20, 1'b1, 1'b0, 5'd0, 1'b0, 5'd21, 5'd0, 1'b1, 1'b0, 5'd21, 1'b1, 1'b1, 2'b10, 2'b00, 1'b1, 4'd7}
    };

    task automatic apply(input vec_t v);
        @(posedge clk); #0.5;
        ex_rs1 = v.ers1; ex_rs2 = v.ers2;
        mem_rd = v.mrd;  mem_wen = v.mw; mem_is_load = v.ml;
        wb_rd  = v.wrd;  wb_wen = v.ww;
        id_rs1 = v.irs1; id_rs2 = v.irs2; id_rs1_used = v.iu1; id_rs2_used = v.iu2;
        ex_rd  = v.erd;  ex_wen = v.ew; ex_is_load = v.el;
        @(negedge clk);
    endtask

    task automatic check(input vec_t v, input string tag);
        checks++;
        if (fwd_a_sel !== v.ea || fwd_b_sel !== v.eb || stall !== v.es || bubble !== v.es) begin
            errors++;
            $display("FAIL %s (R%0d): a=%b b=%b stall=%b bubble=%b expected a=%b b=%b stall/bubble=%b",
                     tag, v.req, fwd_a_sel, fwd_b_sel, stall, bubble, v.ea, v.eb, v.es);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        vec_t v;
        // idle pipeline: all entries empty
        v = '0;
        apply(v);
        check(v, "idle state R5");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(VECS[i], "table");
        end

        // R1 sweep: every non-zero register forwards from execute/memory
        for (int r = 1; r < 32; r++) begin
            v = '0;
            v.ers1 = 5'(r); v.ers2 = 5'(r); v.mrd = 5'(r); v.mw = 1'b1;
            v.ea = 2'b10; v.eb = 2'b10; v.req = 4'd1;
            apply(v);
            check(v, "R1 sweep");
        end

        // R4 corner: source 0 while write-back names a live register
        v = '0;
        v.wrd = 5'd31; v.ww = 1'b1; v.ers2 = 5'd31; v.eb = 2'b01; v.req = 4'd4;
        apply(v);
        check(v, "R4 source zero, b forwards");

        // R3 boundary at the highest register
        v = '0;
        v.ers1 = 5'd31; v.mrd = 5'd31; v.mw = 1'b1; v.wrd = 5'd31; v.ww = 1'b1;
        v.ea = 2'b10; v.req = 4'd3;
        apply(v);
        check(v, "R3 register 31");

        // R7 then release: stall drops when the load leaves execute
        v = '0;
        v.irs1 = 5'd22; v.iu1 = 1'b1; v.erd = 5'd22; v.ew = 1'b1; v.el = 1'b1;
        v.es = 1'b1; v.req = 4'd7;
        apply(v);
        check(v, "R7 load-use");
        v.erd = 5'd0; v.ew = 1'b0; v.el = 1'b0; v.es = 1'b0;
        v.wrd = 5'd0; v.mrd = 5'd22; v.mw = 1'b1; v.ml = 1'b1; v.req = 4'd8;
        apply(v);
        check(v, "R8 after bubble");

        done = 1'b1;
        finish_run();
    end

endmodule